// File: doc/BRIEF.md
# Flag-Generating Arithmetic-Logic Unit

This block is the purely combinational datapath core of a small register-based processor. It takes two operands, a three-bit operation code, and a direction bit. From these it produces a result word and a four-bit condition vector. The eight operations are:

- add and subtract
- bitwise AND, OR and XOR
- a one-place shift, where a right shift is arithmetic
- a one-place rotate
- a pass-through of the first operand

The operation code is the low three bits of the processor's arithmetic instruction opcodes. It can therefore be wired straight from the instruction word.

The block only computes the flags. The surrounding processor chooses the operands, sign-extends immediates, and decides whether to latch the condition vector.

Top module: `flag_alu`

## Requirements
- R1: `op_i` selects the operation: 3'b000 add, 3'b001 subtract, 3'b010 AND, 3'b011 OR, 3'b100 XOR, 3'b101 shift, 3'b110 rotate, 3'b111 move. Add returns (a + b) modulo 2^16.
- R2: For add, carry (flags bit 3) is the carry out of bit 15. Overflow (flags bit 1) is 1 exactly when both operands share a sign and the result sign differs from it.
- R3: Subtract returns (a - b) modulo 2^16. Carry is the borrow: it is 1 exactly when a < b unsigned. Overflow is 1 when the operand signs differ and the result sign differs from the sign of a.
- R4: AND, OR and XOR return the bitwise result, with carry and overflow both 0.
- R5: Shift with `dir_i`=0 moves a left one place and fills bit 0 with 0. Carry takes the old bit 15.
- R6: Shift with `dir_i`=1 moves a right one place and keeps bit 15 unchanged. Carry takes the old bit 0.
- R7: Rotate moves a one place, left when `dir_i`=0 and right when `dir_i`=1, feeding the bit that leaves into the opposite end. Carry and overflow are 0.
- R8: Move returns a unchanged and ignores b. Carry and overflow are 0, and zero and negative are still derived from the result.
- R9: Zero (flags bit 0) is 1 exactly when the result is all zeros. Negative (flags bit 2) equals result bit 15. Both rules hold for every operation.
- R10: The condition vector is ordered {carry, negative, overflow, zero} from bit 3 down to bit 0.
- R11: `dir_i` has no effect on add, subtract, AND, OR, XOR or move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (low three bits of the instruction opcode) |
| dir_i | input | 1 | Direction for shift and rotate: 0 left, 1 right |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| result_o | output | 16 | Operation result |
| flags_o | output | 4 | Condition vector {carry, negative, overflow, zero} |

## Verification
Some properties are checked on every input change, against each other rather than against a full model:

- the borrow agrees with an unsigned comparison;
- add overflow only arises from like-signed operands;
- an arithmetic right shift keeps the sign;
- a rotate keeps the count of ones;
- logic operations and move leave carry and overflow clear;
- zero and negative track the result.

Exact result values need the bench's scenarios. So do the particular carry-out and overflow boundaries (0x7FFF+1, 0x8000+0x8000, 0x8000-1, 0x7FFF-0xFFFF), the bit that leaves on each shift end, and the fact that the direction bit is ignored outside shift and rotate.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'b000,
      OP_SUB   = 3'b001,
      OP_AND   = 3'b010,
      OP_OR    = 3'b011,
      OP_XOR   = 3'b100,
      OP_SHIFT = 3'b101,
      OP_ROT   = 3'b110,
      OP_MOVE  = 3'b111
   } alu_op_e;

   localparam int NUM_FLAGS = 4;
   localparam int FLAG_Z    = 0;
   localparam int FLAG_V    = 1;
   localparam int FLAG_N    = 2;
   localparam int FLAG_C    = 3;

   typedef logic [NUM_FLAGS-1:0] flag_vec_t;

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
   parameter int WIDTH         = 16,
   parameter bit RIPPLE_ADDER  = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             carry_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum_raw;
   logic             cout;

   assign b_eff = sub_i ? ~b_i : b_i;

   generate
      if (RIPPLE_ADDER) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = sub_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_raw[i]  = a_i[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1]  = (a_i[i] & b_eff[i]) | (chain[i] & (a_i[i] ^ b_eff[i]));
         end
         assign cout = chain[WIDTH];
      end else begin : g_infer
         logic [WIDTH:0] wide_sum;
         assign wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
         assign sum_raw  = wide_sum[WIDTH-1:0];
         assign cout     = wide_sum[WIDTH];
      end
   endgenerate

   assign sum_o   = sum_raw;
   // subtract reports a borrow, which is the inverted adder carry
   assign carry_o = sub_i ? ~cout : cout;
   assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_raw[MSB] != a_i[MSB]);

   always_comb begin
      // R3: borrow agrees with an unsigned comparison
      a_r3_borrow_is_less_than: assert (!sub_i || (carry_o == (a_i < b_i)));
      // R2: an add can only overflow with like-signed operands
      a_r2_ovf_like_signs: assert (sub_i || !ovf_o || (a_i[MSB] == b_i[MSB]));
   end

endmodule

// File: rtl/flag_alu_shifter.sv
module flag_alu_shifter #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic             rotate_i,
   input  logic             right_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] res;
   logic             cout;

   always_comb begin
      res  = a_i;
      cout = 1'b0;
      unique case ({rotate_i, right_i})
         2'b00: begin
            res  = {a_i[MSB-1:0], 1'b0};
            cout = a_i[MSB];
         end
         2'b01: begin
            res  = {a_i[MSB], a_i[MSB:1]};
            cout = a_i[0];
         end
         2'b10: res = {a_i[MSB-1:0], a_i[MSB]};
         2'b11: res = {a_i[0], a_i[MSB:1]};
         default: res = a_i;
      endcase

      // R6: arithmetic right shift keeps the sign bit
      a_r6_sign_kept: assert (rotate_i || !right_i || (res[MSB] == a_i[MSB]));
      // R5: left shift fills bit 0 with zero
      a_r5_left_fill_zero: assert (rotate_i || right_i || (res[0] == 1'b0));
      // R7: rotation preserves the number of set bits and never sets carry
      a_r7_rot_popcount: assert (!rotate_i || (($countones(res) == $countones(a_i)) && !cout));
   end

   assign res_o   = res;
   assign carry_o = cout;

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
   import flag_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] result_i,
   input  logic             carry_i,
   input  logic             ovf_i,
   output flag_vec_t        flags_o
);
   always_comb begin
      flags_o         = '0;
      flags_o[FLAG_Z] = ~|result_i;
      flags_o[FLAG_V] = ovf_i;
      flags_o[FLAG_N] = result_i[WIDTH-1];
      flags_o[FLAG_C] = carry_i;
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int WIDTH        = 16,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  logic [2:0]       op_i,
   input  logic             dir_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] result_o,
   output logic [3:0]       flags_o
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("flag_alu: WIDTH must be at least 2");
      end
      if (NUM_FLAGS != 4) begin : g_bad_flags
         $error("flag_alu: condition vector must have four bits");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] as_sum;
   logic             as_carry;
   logic             as_ovf;
   logic [WIDTH-1:0] sh_res;
   logic             sh_carry;
   logic [WIDTH-1:0] res;
   logic             carry;
   logic             ovf;
   flag_vec_t        flags;

   assign op = alu_op_e'(op_i);

   flag_alu_addsub #(
      .WIDTH        (WIDTH),
      .RIPPLE_ADDER (RIPPLE_ADDER)
   ) addsub_i (
      .a_i     (a_i),
      .b_i     (b_i),
      .sub_i   (op == OP_SUB),
      .sum_o   (as_sum),
      .carry_o (as_carry),
      .ovf_o   (as_ovf)
   );

   flag_alu_shifter #(
      .WIDTH (WIDTH)
   ) shifter_i (
      .a_i      (a_i),
      .rotate_i (op == OP_ROT),
      .right_i  (dir_i),
      .res_o    (sh_res),
      .carry_o  (sh_carry)
   );

   always_comb begin
      res   = a_i;
      carry = 1'b0;
      ovf   = 1'b0;
      unique case (op)
         OP_ADD, OP_SUB: begin
            res   = as_sum;
            carry = as_carry;
            ovf   = as_ovf;
         end
         OP_AND:   res = a_i & b_i;
         OP_OR:    res = a_i | b_i;
         OP_XOR:   res = a_i ^ b_i;
         OP_SHIFT: begin
            res   = sh_res;
            carry = sh_carry;
         end
         OP_ROT:   res = sh_res;
         OP_MOVE:  res = a_i;
         default:  res = a_i;
      endcase
   end

   flag_alu_flags #(
      .WIDTH (WIDTH)
   ) flags_i (
      .result_i (res),
      .carry_i  (carry),
      .ovf_i    (ovf),
      .flags_o  (flags)
   );

   assign result_o = res;
   assign flags_o  = flags;

   always_comb begin
      // R4: logic operations leave carry and overflow clear
      a_r4_logic_no_cv: assert (!(op inside {OP_AND, OP_OR, OP_XOR}) ||
                                (!flags[FLAG_C] && !flags[FLAG_V]));
      // R8: move returns the first operand with carry and overflow clear
      a_r8_move_pass: assert (op != OP_MOVE ||
                              ((res == a_i) && !flags[FLAG_C] && !flags[FLAG_V]));
      // R9: zero and negative track the result word
      a_r9_zn_track: assert ((flags[FLAG_Z] == (res == '0)) && (flags[FLAG_N] == res[MSB]));
   end

endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;

   logic        clk = 1'b0;
   logic [2:0]  op;
   logic        dir;
   logic [15:0] a;
   logic [15:0] b;
   logic [15:0] result;
   logic [3:0]  flags;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   flag_alu dut_i (
      .op_i     (op),
      .dir_i    (dir),
      .a_i      (a),
      .b_i      (b),
      .result_o (result),
      .flags_o  (flags)
   );

   // {req[3:0], op[2:0], dir, a[15:0], b[15:0], expected result[15:0], expected flags {C,N,V,Z}}
   localparam int NV = 22;
   localparam logic [59:0] VECS [0:NV-1] = '{
      {4'd1,  3'b000, 1'b0, 16'h0001, 16'h0002, 16'h0003, 4'b0000}, // R1 plain add
      {4'd2,  3'b000, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 4'b1001}, // R2 carry out, zero
      {4'd2,  3'b000, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 4'b0110}, // R2 positive overflow
      {4'd2,  3'b000, 1'b0, 16'h8000, 16'h8000, 16'h0000, 4'b1011}, // R2 negative overflow
      {4'd3,  3'b001, 1'b0, 16'h0005, 16'h0003, 16'h0002, 4'b0000}, // R3 no borrow
      {4'd3,  3'b001, 1'b0, 16'h0003, 16'h0005, 16'hFFFE, 4'b1100}, // R3 borrow
      {4'd3,  3'b001, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 4'b0010}, // R3 overflow
      {4'd3,  3'b001, 1'b0, 16'h1234, 16'h1234, 16'h0000, 4'b0001}, // R3 equal
      {4'd3,  3'b001, 1'b0, 16'h7FFF, 16'hFFFF, 16'h8000, 4'b1110}, // R3 borrow+overflow
      {4'd4,  3'b010, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 4'b0000}, // R4 AND
      {4'd4,  3'b011, 1'b0, 16'h8000, 16'h0001, 16'h8001, 4'b0100}, // R4 OR
      {4'd4,  3'b100, 1'b0, 16'hAAAA, 16'hAAAA, 16'h0000, 4'b0001}, // R4 XOR
      {4'd5,  3'b101, 1'b0, 16'h8001, 16'h0000, 16'h0002, 4'b1000}, // R5 msb out
      {4'd5,  3'b101, 1'b0, 16'h4000, 16'h0000, 16'h8000, 4'b0100}, // R5 into sign
      {4'd6,  3'b101, 1'b1, 16'h8003, 16'h0000, 16'hC001, 4'b1100}, // R6 sign kept
      {4'd6,  3'b101, 1'b1, 16'h0001, 16'h0000, 16'h0000, 4'b1001}, // R6 lsb out
      {4'd7,  3'b110, 1'b0, 16'h8001, 16'h0000, 16'h0003, 4'b0000}, // R7 rotate left
      {4'd7,  3'b110, 1'b1, 16'h0001, 16'h0000, 16'h8000, 4'b0100}, // R7 rotate right
      {4'd8,  3'b111, 1'b0, 16'h0000, 16'hFFFF, 16'h0000, 4'b0001}, // R8 move zero
      {4'd8,  3'b111, 1'b1, 16'h9000, 16'h1234, 16'h9000, 4'b0100}, // R8 move negative
      {4'd11, 3'b000, 1'b1, 16'h0001, 16'h0002, 16'h0003, 4'b0000}, // R11 add ignores dir
      {4'd11, 3'b100, 1'b1, 16'h00FF, 16'h0F0F, 16'h0FF0, 4'b0000}  // R11 xor ignores dir
   };

   task automatic apply(input logic [2:0] o, input logic d,
                        input logic [15:0] va, input logic [15:0] vb);
      @(posedge clk);
      op  <= o;
      dir <= d;
      a   <= va;
      b   <= vb;
      @(negedge clk);
   endtask

   task automatic check_out(input int req, input logic [15:0] er, input logic [3:0] ef);
      checks++;
      if (result !== er || flags !== ef) begin
         fails++;
         $display("FAIL R%0d: result=%h flags=%b expected result=%h flags=%b",
                  req, result, flags, er, ef);
      end
   endtask

   task automatic check_bit(input int req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: flag bit=%b expected=%b", req, act, exp);
      end
   endtask

   initial begin
      op  = 3'b000;
      dir = 1'b0;
      a   = '0;
      b   = '0;
      @(negedge clk);
      // idle state with all-zero inputs: add of zeros, only zero flag (R9)
      check_out(9, 16'h0000, 4'b0001);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i][55:53], VECS[i][52], VECS[i][51:36], VECS[i][35:20]);
         check_out(int'(VECS[i][59:56]), VECS[i][19:4], VECS[i][3:0]);
      end

      // R10: individual bit positions, 0x8000+0x8000 gives C=1 N=0 V=1 Z=1
      apply(3'b000, 1'b0, 16'h8000, 16'h8000);
      check_bit(10, flags[3], 1'b1);
      check_bit(10, flags[2], 1'b0);
      check_bit(10, flags[1], 1'b1);
      check_bit(10, flags[0], 1'b1);

      // R9: negative follows bit 15 of an AND result
      apply(3'b010, 1'b0, 16'hFFFF, 16'h8000);
      check_out(9, 16'h8000, 4'b0100);

      // R11: subtract and OR unchanged by dir
      apply(3'b001, 1'b1, 16'h0003, 16'h0005);
      check_out(11, 16'hFFFE, 4'b1100);
      apply(3'b011, 1'b1, 16'h0F00, 16'h00F0);
      check_out(11, 16'h0FF0, 4'b0000);

      // R8: move ignores b
      apply(3'b111, 1'b0, 16'h0042, 16'hDEAD);
      check_out(8, 16'h0042, 4'b0000);

      // R7: full-ones rotate stays all ones, carry clear
      apply(3'b110, 1'b1, 16'hFFFF, 16'h0000);
      check_out(7, 16'hFFFF, 4'b0100);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule